// File: doc/BRIEF.md
# Boot-Mode Reset Sequencer

This block puts a target microcontroller into one of two boot modes. It drives the target's reset line, which is active high, and a serial-bus chip-select line, which is active low, in a fixed timed order. The level of chip-select while reset is released decides the mode. If chip-select is held asserted across the reset pulse and the startup wait that follows, the target boots into its serial flash-programming mode. If chip-select stays idle, the target boots normally.

A one-cycle strobe on `enter_req` or `exit_req` starts a sequence. While a sequence runs, the block holds a bus-hold request (`bus_req`) so that no other serial traffic can interleave with it. Every delay is counted in millisecond ticks, and a parameterised prescaler divides the ticks down from the system clock. A one-cycle `done` pulse marks the end of a sequence. The serial data path and the flash command set belong to other blocks.

Top module: `boot_mode_seq`

## Requirements
- R1: After reset, `tgt_rst` is low, `tgt_cs_n` is high, and `busy`, `bus_req` and `done` are low.
- R2: An `enter_req` strobe accepted while idle drives `tgt_cs_n` low and `busy` high from the next cycle onward. It keeps `tgt_rst` low for CS_SETUP_MS*CLKS_PER_MS cycles.
- R3: In an entry sequence, `tgt_rst` is then high for RST_PULSE_MS*CLKS_PER_MS cycles, and `tgt_cs_n` stays low throughout.
- R4: In an entry sequence, `tgt_rst` then returns low while `tgt_cs_n` stays low for STARTUP_MS*CLKS_PER_MS cycles. After that, `tgt_cs_n` goes high and `busy` goes low in the same cycle.
- R5: An `exit_req` strobe accepted while idle raises `tgt_rst` in the next cycle for RST_PULSE_MS*CLKS_PER_MS cycles. A startup wait of STARTUP_MS*CLKS_PER_MS cycles follows. `tgt_cs_n` stays high through the whole sequence.
- R6: `done` is high for exactly one cycle, the first idle cycle after a sequence ends.
- R7: A request of either kind that arrives while `busy` is high is ignored. The running sequence keeps its timing and its chip-select level.
- R8: If `enter_req` and `exit_req` arrive in the same idle cycle, the entry sequence runs.
- R9: `bus_req` is high in exactly the cycles in which `busy` is high. It therefore covers the whole sequence, including every cycle in which `tgt_rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enter_req | input | 1 | Strobe: start the programming-mode entry sequence |
| exit_req | input | 1 | Strobe: start the normal-mode return sequence |
| tgt_rst | output | 1 | Target reset, active high |
| tgt_cs_n | output | 1 | Target chip-select, active low |
| bus_req | output | 1 | Hold request on the shared serial bus |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The bench builds the block with CLKS_PER_MS=4, CS_SETUP_MS=3, RST_PULSE_MS=2 and STARTUP_MS=3. With these values a full entry sequence lasts 32 cycles and an exit sequence lasts 20. That is short enough to compare every output on every cycle against a schedule the bench computes itself. The same values exercise every prescaler wrap and every phase boundary, the done cycle, a request that arrives mid-sequence, and the tie between the two strobes.

// File: rtl/boot_mode_seq_pkg.sv
// Shared types for the boot-mode reset sequencer.
package boot_mode_seq_pkg;

    // Phases of a sequence; an exit sequence skips PH_CS_SETUP.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_CS_SETUP = 2'd1,
        PH_RST      = 2'd2,
        PH_STARTUP  = 2'd3
    } phase_t;

endpackage

// File: rtl/ms_prescaler.sv
// Millisecond prescaler.
// Produces a combinational tick once every CLKS_PER_MS cycles. The 'clear'
// input restarts the count, so the first tick after a clear comes exactly
// CLKS_PER_MS cycles later.
// Assumes CLKS_PER_MS >= 2.
module ms_prescaler #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int PW = (CLKS_PER_MS > 2) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    logic [PW-1:0] presc_q;

    // Count cycles within one millisecond and wrap at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (clear || presc_q == LAST) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    assign tick = (presc_q == LAST);

    // The count never leaves its range (supports the timing in R2).
    a_r2_presc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q <= LAST);

endmodule

// File: rtl/ms_countdown.sv
// Millisecond countdown.
// 'load' arms the timer with load_val ticks. 'expire' is high in the cycle of
// the final tick, so a phase loaded at one edge ends exactly
// load_val*CLKS_PER_MS edges later. Assumes load_val is non-zero.
module ms_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] remain_q;
    logic             running_q;

    // Hold the remaining tick count and decrement it on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q  <= '0;
            running_q <= 1'b0;
        end else if (load) begin
            remain_q  <= load_val;
            running_q <= 1'b1;
        end else if (running_q && tick) begin
            remain_q  <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) begin
                running_q <= 1'b0;
            end
        end
    end

    assign expire = running_q && tick && (remain_q == CNT_W'(1));

    // An armed timer never counts below one (R3 and R4 phase lengths).
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (remain_q != '0));

endmodule

// File: rtl/boot_mode_fsm.sv
// Sequence controller.
// Accepts a request only while idle, with entry taking priority over exit. It
// steps through the phases when the countdown expires and drives registered,
// glitch-free pin levels. Assumes the countdown's expire pulse is one cycle
// long.
module boot_mode_fsm
    import boot_mode_seq_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int CS_SETUP_MS  = 200,
    parameter int RST_PULSE_MS = 100,
    parameter int STARTUP_MS   = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_req,
    input  logic             exit_req,
    input  logic             expire,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_len,
    output logic             tgt_rst,
    output logic             tgt_cs_n,
    output logic             busy,
    output logic             bus_req,
    output logic             done
);
    localparam logic [CNT_W-1:0] LEN_CS  = CNT_W'(CS_SETUP_MS);
    localparam logic [CNT_W-1:0] LEN_RST = CNT_W'(RST_PULSE_MS);
    localparam logic [CNT_W-1:0] LEN_SU  = CNT_W'(STARTUP_MS);

    phase_t phase_q, phase_d;
    logic   prog_q, prog_d;
    logic   done_d;
    logic   rst_q, cs_n_q, busy_q, bus_q, done_q;

    // Next-phase selection and timer loading.
    always_comb begin
        phase_d  = phase_q;
        prog_d   = prog_q;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = LEN_RST;
        unique case (phase_q)
            PH_IDLE: begin
                if (enter_req) begin
                    phase_d  = PH_CS_SETUP;
                    prog_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_CS;
                end else if (exit_req) begin
                    phase_d  = PH_RST;
                    prog_d   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_RST;
                end
            end
            PH_CS_SETUP: begin
                if (expire) begin
                    phase_d  = PH_RST;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_RST;
                end
            end
            PH_RST: begin
                if (expire) begin
                    phase_d  = PH_STARTUP;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_SU;
                end
            end
            PH_STARTUP: begin
                if (expire) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase and mode registers, plus pin levels registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            prog_q  <= 1'b0;
            rst_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
            bus_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            prog_q  <= prog_d;
            rst_q   <= (phase_d == PH_RST);
            cs_n_q  <= !(prog_d && phase_d != PH_IDLE);
            busy_q  <= (phase_d != PH_IDLE);
            bus_q   <= (phase_d != PH_IDLE);
            done_q  <= done_d;
        end
    end

    assign tgt_rst  = rst_q;
    assign tgt_cs_n = cs_n_q;
    assign busy     = busy_q;
    assign bus_req  = bus_q;
    assign done     = done_q;

    // R9: the target is never in reset without the bus being held.
    a_r9_rst_under_bus: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst |-> bus_req);

    // R4: chip-select is released only as an entry sequence completes.
    a_r4_cs_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_cs_n) |-> done);

    // R6: done lasts a single cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the mode cannot change while a sequence runs.
    a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> $stable(prog_q));

    // R5: an exit sequence never asserts chip-select.
    a_r5_exit_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_q) |-> tgt_cs_n);

endmodule

// File: rtl/boot_mode_seq.sv
// Boot-mode reset sequencer (top).
// Ties the prescaler, the countdown and the sequence controller together.
// Delay parameters are in milliseconds, CLKS_PER_MS is clock cycles per
// millisecond, and every delay parameter must be at least 1.
module boot_mode_seq #(
    parameter int CLKS_PER_MS  = 50000,
    parameter int CS_SETUP_MS  = 200,
    parameter int RST_PULSE_MS = 100,
    parameter int STARTUP_MS   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exit_req,
    output logic tgt_rst,
    output logic tgt_cs_n,
    output logic bus_req,
    output logic busy,
    output logic done
);
    localparam int MAX_A  = (CS_SETUP_MS > RST_PULSE_MS) ? CS_SETUP_MS : RST_PULSE_MS;
    localparam int MAX_MS = (MAX_A > STARTUP_MS) ? MAX_A : STARTUP_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    logic             tick;
    logic             expire;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;

    ms_prescaler #(
        .CLKS_PER_MS (CLKS_PER_MS)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_load),
        .tick  (tick)
    );

    ms_countdown #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_len),
        .tick     (tick),
        .expire   (expire)
    );

    boot_mode_fsm #(
        .CNT_W        (CNT_W),
        .CS_SETUP_MS  (CS_SETUP_MS),
        .RST_PULSE_MS (RST_PULSE_MS),
        .STARTUP_MS   (STARTUP_MS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_req (enter_req),
        .exit_req  (exit_req),
        .expire    (expire),
        .tmr_load  (tmr_load),
        .tmr_len   (tmr_len),
        .tgt_rst   (tgt_rst),
        .tgt_cs_n  (tgt_cs_n),
        .busy      (busy),
        .bus_req   (bus_req),
        .done      (done)
    );

    // R1: while reset is held, the next edge leaves the target running and the bus free.
    a_r1_reset_levels: assert property (@(posedge clk)
        !rst_n |=> (!tgt_rst && tgt_cs_n && !busy && !done));

endmodule

// File: tb/boot_mode_seq_tb.sv
// Directed bench for the boot-mode reset sequencer.
module boot_mode_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam int CSU = 3;
    localparam int RP  = 2;
    localparam int SU  = 3;
    // Entry phase boundaries, counted in edges after the accepting edge.
    localparam int E1 = CSU * DIV;
    localparam int E2 = E1 + RP * DIV;
    localparam int E3 = E2 + SU * DIV;
    // Exit phase boundaries.
    localparam int X1 = RP * DIV;
    localparam int X2 = X1 + SU * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 1'b0;
    logic exit_req = 1'b0;
    logic tgt_rst, tgt_cs_n, bus_req, busy, done;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_mode_seq #(
        .CLKS_PER_MS (DIV),
        .CS_SETUP_MS (CSU),
        .RST_PULSE_MS(RP),
        .STARTUP_MS  (SU)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .tgt_rst(tgt_rst), .tgt_cs_n(tgt_cs_n), .bus_req(bus_req),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what, input int k,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at k=%0d actual=%b expected=%b", req, what, k, act, exp);
        end
    endtask

    // Compare all outputs against expected levels; bus_req must track busy (R9).
    task automatic expect_all(input string req, input int k, input logic e_rst,
                              input logic e_cs_n, input logic e_busy, input logic e_done);
        chk(req, "tgt_rst", k, tgt_rst, e_rst);
        chk(req, "tgt_cs_n", k, tgt_cs_n, e_cs_n);
        chk(req, "busy", k, busy, e_busy);
        chk("R9", "bus_req", k, bus_req, e_busy);
        chk("R6", "done", k, done, e_done);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_all("R1", 0, 1'b0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R1", 1, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    // Entry sequence; 'mode' 0 = plain, 1 = strobes injected while busy (R7),
    // 2 = both strobes together (R8). Checked on every cycle.
    task automatic t_entry(input int mode);
        @(negedge clk);
        enter_req = 1'b1;
        exit_req  = (mode == 2);
        @(posedge clk);
        @(negedge clk);
        enter_req = 1'b0;
        exit_req  = 1'b0;
        for (int k = 0; k <= E3 + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (k < E1)
                expect_all(mode == 2 ? "R8" : "R2", k, 1'b0, 1'b0, 1'b1, 1'b0);
            else if (k < E2)
                expect_all(mode == 1 ? "R7" : "R3", k, 1'b1, 1'b0, 1'b1, 1'b0);
            else if (k < E3)
                expect_all("R4", k, 1'b0, 1'b0, 1'b1, 1'b0);
            else if (k == E3)
                expect_all("R4", k, 1'b0, 1'b1, 1'b0, 1'b1);
            else
                expect_all("R6", k, 1'b0, 1'b1, 1'b0, 1'b0);
            if (mode == 1) begin
                exit_req  = (k == 3) || (k == E2 + 2);
                enter_req = (k == E1 + 1) || (k == E3 - 1);
            end
        end
        exit_req = 1'b0;
        enter_req = 1'b0;
    endtask

    // Exit sequence, checked on every cycle (R5).
    task automatic t_exit();
        @(negedge clk);
        exit_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exit_req = 1'b0;
        for (int k = 0; k <= X2 + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (k < X1)
                expect_all("R5", k, 1'b1, 1'b1, 1'b1, 1'b0);
            else if (k < X2)
                expect_all("R5", k, 1'b0, 1'b1, 1'b1, 1'b0);
            else if (k == X2)
                expect_all("R6", k, 1'b0, 1'b1, 1'b0, 1'b1);
            else
                expect_all("R6", k, 1'b0, 1'b1, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R0 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_entry(0);
        t_exit();
        t_entry(1);
        t_entry(2);
        t_exit();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule